// File: doc/BRIEF.md
# Slot Operand Crossbar with Latency-Partitioned Result Registers

This block is the operand delivery network of a statically scheduled machine with several execution slots. Every slot owns a small result store that is split by operation latency. Each latency class of a slot holds two result registers, and only that slot's functional units of that latency can write them, through their own write port with a one-bit local index. The functional units, the decoder and the scheduler sit outside the block. Results arrive on one write port per slot and latency class.

Every slot has two operand ports. Each port picks any result register of any slot through a global source address, and it returns the value in the same cycle. A port can instead take the bypass path. That path delivers the most recent latency-1 result of a named slot, so a one-cycle result can feed a one-cycle operation in any slot on the next cycle. The bypass path is held in one dedicated register per slot, apart from the indexed store.

The block has no flow control at either edge. A write with its valid bit set is always accepted at the next clock edge, and no ready signal exists, because a statically scheduled producer cannot be stalled. Operand reads are purely combinational and are likewise never refused. The operand data is meaningful only in the cycle in which the address is presented.

Top module: `xbar_operand_net`

## Requirements
- R1: Operand port p (p = slot*2 + n, n in {0,1}) reads the register chosen by its 5-bit global address. The address fields are: bit 0 = local index, bits [2:1] = latency class (0 = latency 1, 1 = latency 2, 2 = latency 3), bits [4:3] = slot.
- R2: Write port k (k = slot*3 + class) has a valid bit, a 1-bit local index and 32-bit data. When valid is high, the clock edge stores the data into register {slot, class, index}, and only that register changes.
- R3: A read of a register in the same cycle as a write to it returns the value held before the write. The new value is visible from the next cycle on.
- R4: Writes on different write ports in the same cycle, across latency classes and slots, all take effect at the same edge.
- R5: A read whose class field is 3 (outside classes 0 to 2) or whose slot field is not a present slot returns zero and raises that port's error flag. A valid read keeps the error flag low.
- R6: When a port's bypass bit is set, the port returns the latency-1 value (class 0 write port) that the slot named by its 2-bit bypass-slot field wrote in the previous cycle. The error flag stays low.
- R7: Each slot's bypass register keeps the last latency-1 value written, whatever its index, and holds it through cycles with no latency-1 write. A later write to the other index does not change what the indexed store holds at the first index.
- R8: A synchronous active-high reset clears every result register and bypass register to zero. Writes presented during reset are dropped.
- R9: Operand data follows the address combinationally, with no clock edge between an address change and the new data.
- R10: A write port whose valid bit is low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_vld | input | 12 | Write valid, one bit per slot and latency class (k = slot*3 + class) |
| wr_idx | input | 12 | Local register index, one bit per write port |
| wr_data | input | 384 | Write data, 32 bits per write port |
| op_addr | input | 40 | Global source address, 5 bits per operand port |
| op_byp | input | 8 | Bypass select, one bit per operand port |
| op_byp_slot | input | 16 | Slot whose latency-1 result the bypass takes, 2 bits per port |
| op_data | output | 256 | Operand data, 32 bits per operand port |
| op_err | output | 8 | Out-of-range address flag, one bit per operand port |

## Verification
Several behaviours are checked every cycle on every port. A committed write is seen next cycle by any port that addresses it. A bypass read returns the named slot's latency-1 value from the cycle before. A flagged read yields zero, and the first cycle after reset yields zero everywhere. Other behaviours only the bench scenarios can show. These are the old value on a same-cycle read, the independence of the bypass register from the indexed store, many classes written at one edge, invalid writes leaving state alone, and the match against a reference model under random traffic.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  // Result registers per latency class and operand ports per slot are fixed by the architecture.
  localparam int REGS_PER_CLASS = 2;
  localparam int PORTS_PER_SLOT = 2;

  // Field width for n choices, never below one bit.
  function automatic int field_w(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/xb_result_bank.sv
module xb_result_bank #(
  parameter int DW    = 32,
  parameter int N_REG = 2,
  localparam int IDX_W = xbar_pkg::field_w(N_REG)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_vld,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [DW-1:0]         wr_data,
  output logic [N_REG*DW-1:0]   q
);
  logic [DW-1:0] r [N_REG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < N_REG; j++) r[j] <= '0;
    end else if (wr_vld) begin
      r[wr_idx] <= wr_data;
    end
  end

  for (genvar j = 0; j < N_REG; j++) begin : g_out
    assign q[j*DW +: DW] = r[j];
  end
endmodule

// File: rtl/xb_bypass_reg.sv
module xb_bypass_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (cap) q <= d;
  end
endmodule

// File: rtl/xb_operand_mux.sv
module xb_operand_mux #(
  parameter int N_SLOT  = 4,
  parameter int N_CLASS = 3,
  parameter int DW      = 32,
  localparam int N_REG  = xbar_pkg::REGS_PER_CLASS,
  localparam int SLOT_W = xbar_pkg::field_w(N_SLOT),
  localparam int CLS_W  = xbar_pkg::field_w(N_CLASS),
  localparam int IDX_W  = xbar_pkg::field_w(N_REG),
  localparam int AW     = SLOT_W + CLS_W + IDX_W,
  localparam int N_ENT  = N_SLOT * N_CLASS * N_REG,
  localparam int ENT_W  = xbar_pkg::field_w(N_ENT)
) (
  input  logic [N_ENT*DW-1:0]  file_q,
  input  logic [N_SLOT*DW-1:0] byp_q,
  input  logic [AW-1:0]        addr,
  input  logic                 byp,
  input  logic [SLOT_W-1:0]    byp_slot,
  output logic [DW-1:0]        data,
  output logic                 err
);
  logic [DW-1:0] ent_a [N_ENT];
  logic [DW-1:0] byp_a [N_SLOT];

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    assign ent_a[e] = file_q[e*DW +: DW];
  end
  for (genvar s = 0; s < N_SLOT; s++) begin : g_byp
    assign byp_a[s] = byp_q[s*DW +: DW];
  end

  logic [SLOT_W-1:0] slot_f;
  logic [CLS_W-1:0]  cls_f;
  logic [IDX_W-1:0]  idx_f;
  assign slot_f = addr[AW-1 -: SLOT_W];
  assign cls_f  = addr[IDX_W +: CLS_W];
  assign idx_f  = addr[IDX_W-1:0];

  always_comb begin
    int s_i;
    int c_i;
    int b_i;
    s_i  = int'(slot_f);
    c_i  = int'(cls_f);
    b_i  = int'(byp_slot);
    data = '0;
    err  = 1'b0;
    if (byp) begin
      if (b_i < N_SLOT) data = byp_a[byp_slot];
      else              err  = 1'b1;
    end else if (s_i < N_SLOT && c_i < N_CLASS) begin
      data = ent_a[ENT_W'((s_i*N_CLASS + c_i)*N_REG + int'(idx_f))];
    end else begin
      err = 1'b1;
    end
  end
endmodule

// File: rtl/xbar_operand_net.sv
module xbar_operand_net #(
  parameter int N_SLOT  = 4,
  parameter int N_CLASS = 3,
  parameter int DW      = 32,
  localparam int N_REG  = xbar_pkg::REGS_PER_CLASS,
  localparam int SLOT_W = xbar_pkg::field_w(N_SLOT),
  localparam int CLS_W  = xbar_pkg::field_w(N_CLASS),
  localparam int IDX_W  = xbar_pkg::field_w(N_REG),
  localparam int AW     = SLOT_W + CLS_W + IDX_W,
  localparam int N_WP   = N_SLOT * N_CLASS,
  localparam int N_RP   = N_SLOT * xbar_pkg::PORTS_PER_SLOT
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_WP-1:0]        wr_vld,
  input  logic [N_WP*IDX_W-1:0]  wr_idx,
  input  logic [N_WP*DW-1:0]     wr_data,
  input  logic [N_RP*AW-1:0]     op_addr,
  input  logic [N_RP-1:0]        op_byp,
  input  logic [N_RP*SLOT_W-1:0] op_byp_slot,
  output logic [N_RP*DW-1:0]     op_data,
  output logic [N_RP-1:0]        op_err
);
  logic [N_WP*N_REG*DW-1:0] file_q;
  logic [N_SLOT*DW-1:0]     byp_q;

  // One bank per (slot, latency class); write port k = slot*N_CLASS + class.
  for (genvar k = 0; k < N_WP; k++) begin : g_bank
    xb_result_bank #(.DW(DW), .N_REG(N_REG)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_vld  (wr_vld[k]),
      .wr_idx  (wr_idx[k*IDX_W +: IDX_W]),
      .wr_data (wr_data[k*DW +: DW]),
      .q       (file_q[k*N_REG*DW +: N_REG*DW])
    );
  end

  // Next-cycle path: class 0 of each slot is the single-cycle latency.
  for (genvar s = 0; s < N_SLOT; s++) begin : g_fast
    xb_bypass_reg #(.DW(DW)) u_fast (
      .clk (clk),
      .rst (rst),
      .cap (wr_vld[s*N_CLASS]),
      .d   (wr_data[s*N_CLASS*DW +: DW]),
      .q   (byp_q[s*DW +: DW])
    );
  end

  for (genvar p = 0; p < N_RP; p++) begin : g_port
    xb_operand_mux #(.N_SLOT(N_SLOT), .N_CLASS(N_CLASS), .DW(DW)) u_mux (
      .file_q   (file_q),
      .byp_q    (byp_q),
      .addr     (op_addr[p*AW +: AW]),
      .byp      (op_byp[p]),
      .byp_slot (op_byp_slot[p*SLOT_W +: SLOT_W]),
      .data     (op_data[p*DW +: DW]),
      .err      (op_err[p])
    );
  end
endmodule

// File: rtl/xb_checker.sv
module xb_checker #(
  parameter int N_SLOT  = 4,
  parameter int N_CLASS = 3,
  parameter int DW      = 32,
  localparam int N_REG  = xbar_pkg::REGS_PER_CLASS,
  localparam int SLOT_W = xbar_pkg::field_w(N_SLOT),
  localparam int CLS_W  = xbar_pkg::field_w(N_CLASS),
  localparam int IDX_W  = xbar_pkg::field_w(N_REG),
  localparam int AW     = SLOT_W + CLS_W + IDX_W,
  localparam int N_WP   = N_SLOT * N_CLASS,
  localparam int N_RP   = N_SLOT * xbar_pkg::PORTS_PER_SLOT
) (
  input logic                   clk,
  input logic                   rst,
  input logic [N_WP-1:0]        wr_vld,
  input logic [N_WP*IDX_W-1:0]  wr_idx,
  input logic [N_WP*DW-1:0]     wr_data,
  input logic [N_RP*AW-1:0]     op_addr,
  input logic [N_RP-1:0]        op_byp,
  input logic [N_RP*SLOT_W-1:0] op_byp_slot,
  input logic [N_RP*DW-1:0]     op_data,
  input logic [N_RP-1:0]        op_err
);
  for (genvar p = 0; p < N_RP; p++) begin : g_p
    AST_ERR_GIVES_ZERO: assert property (@(posedge clk) disable iff (rst)
      op_err[p] |-> op_data[p*DW +: DW] == '0); // R5

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> op_data[p*DW +: DW] == '0); // R8

    for (genvar k = 0; k < N_WP; k++) begin : g_k
      localparam logic [SLOT_W-1:0] KS = SLOT_W'(k / N_CLASS);
      localparam logic [CLS_W-1:0]  KC = CLS_W'(k % N_CLASS);
      AST_WRITE_SEEN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_vld[k]) && !op_byp[p] &&
         op_addr[p*AW +: AW] == {KS, KC, $past(wr_idx[k*IDX_W +: IDX_W])})
        |-> op_data[p*DW +: DW] == $past(wr_data[k*DW +: DW])); // R2
    end

    for (genvar s = 0; s < N_SLOT; s++) begin : g_s
      AST_FAST_NEXT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_vld[s*N_CLASS]) && op_byp[p] &&
         op_byp_slot[p*SLOT_W +: SLOT_W] == SLOT_W'(s))
        |-> (op_data[p*DW +: DW] == $past(wr_data[s*N_CLASS*DW +: DW]) && !op_err[p])); // R6
    end
  end
endmodule

bind xbar_operand_net xb_checker #(.N_SLOT(N_SLOT), .N_CLASS(N_CLASS), .DW(DW)) u_chk (.*);

// File: tb/sim_xbar_operand_net.sv
module sim_xbar_operand_net;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11:0]  wr_vld;
  logic [11:0]  wr_idx;
  logic [383:0] wr_data;
  logic [39:0]  op_addr;
  logic [7:0]   op_byp;
  logic [15:0]  op_byp_slot;
  logic [255:0] op_data;
  logic [7:0]   op_err;

  always #10 clk = ~clk; // 50 MHz

  xbar_operand_net u0 (
    .clk(clk), .rst(rst), .wr_vld(wr_vld), .wr_idx(wr_idx), .wr_data(wr_data),
    .op_addr(op_addr), .op_byp(op_byp), .op_byp_slot(op_byp_slot),
    .op_data(op_data), .op_err(op_err)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference state, built from the requirements.
  logic [31:0] mreg [12][2];
  logic [31:0] mfast [4];

  typedef struct packed {
    logic        wv;
    logic [3:0]  wk;
    logic        wi;
    logic [31:0] wd;
    logic [2:0]  rp;
    logic [4:0]  ra;
    logic        rb;
    logic [1:0]  rbs;
    logic [31:0] ed;
    logic        ee;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 4'd0, 1'b0, 32'h11, 3'd0, 5'd0,  1'b0, 2'd0, 32'h0,  1'b0, 4'd3},  // R3 old value on same-cycle read
    '{1'b1, 4'd5, 1'b1, 32'h22, 3'd0, 5'd0,  1'b0, 2'd0, 32'h11, 1'b0, 4'd2},  // R2 write landed
    '{1'b0, 4'd0, 1'b0, 32'h0,  3'd1, 5'd13, 1'b0, 2'd0, 32'h22, 1'b0, 4'd1},  // R1 slot1 class2 idx1
    '{1'b1, 4'd0, 1'b1, 32'h33, 3'd2, 5'd0,  1'b1, 2'd0, 32'h11, 1'b0, 4'd7},  // R7 fast reg holds
    '{1'b0, 4'd0, 1'b0, 32'h0,  3'd3, 5'd0,  1'b1, 2'd0, 32'h33, 1'b0, 4'd6},  // R6 next-cycle path
    '{1'b0, 4'd0, 1'b0, 32'h0,  3'd4, 5'd0,  1'b0, 2'd0, 32'h11, 1'b0, 4'd7},  // R7 index 0 untouched
    '{1'b0, 4'd0, 1'b0, 32'h0,  3'd5, 5'd22, 1'b0, 2'd0, 32'h0,  1'b1, 4'd5},  // R5 class 3
    '{1'b0, 4'd7, 1'b0, 32'h99, 3'd6, 5'd18, 1'b0, 2'd0, 32'h0,  1'b0, 4'd10}, // R10 valid low
    '{1'b0, 4'd0, 1'b0, 32'h0,  3'd7, 5'd18, 1'b0, 2'd0, 32'h0,  1'b0, 4'd10}  // R10 nothing stored
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_vld = '0; wr_idx = '0; wr_data = '0;
    op_addr = '0; op_byp = '0; op_byp_slot = '0;
  endtask

  function automatic logic [4:0] gaddr(input int s, input int c, input int i);
    return 5'((s << 3) | (c << 1) | i);
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 12; k++) begin mreg[k][0] = '0; mreg[k][1] = '0; end
    for (int s = 0; s < 4; s++) mfast[s] = '0;
  endtask

  task automatic model_commit();
    for (int k = 0; k < 12; k++)
      if (wr_vld[k]) mreg[k][wr_idx[k]] = wr_data[k*32 +: 32];
    for (int s = 0; s < 4; s++)
      if (wr_vld[s*3]) mfast[s] = wr_data[s*3*32 +: 32];
  endtask

  initial begin
    idle();
    model_reset();
    repeat (2) @(negedge clk);
    rst = 1'b0;

    // Reset state: every register and fast path reads zero (R8).
    #1;
    for (int p = 0; p < 8; p++) begin
      op_addr[p*5 +: 5] = 5'(p * 3);
      op_byp[p] = p[0];
      op_byp_slot[p*2 +: 2] = 2'(p >> 1);
    end
    #1;
    for (int p = 0; p < 8; p++) chk($sformatf("R8 reset port %0d", p), op_data[p*32 +: 32], 32'h0);

    // Vector table.
    for (int n = 0; n < NV; n++) begin
      @(negedge clk);
      idle();
      wr_vld[TBL[n].wk] = TBL[n].wv;
      wr_idx[TBL[n].wk] = TBL[n].wi;
      wr_data[TBL[n].wk*32 +: 32] = TBL[n].wd;
      op_addr[TBL[n].rp*5 +: 5] = TBL[n].ra;
      op_byp[TBL[n].rp] = TBL[n].rb;
      op_byp_slot[TBL[n].rp*2 +: 2] = TBL[n].rbs;
      #1;
      chk($sformatf("R%0d vec %0d data", TBL[n].req, n), op_data[TBL[n].rp*32 +: 32], TBL[n].ed);
      chk($sformatf("R%0d vec %0d err", TBL[n].req, n), 32'(op_err[TBL[n].rp]), 32'(TBL[n].ee));
    end

    // R4: all twelve write ports fire in one cycle.
    @(negedge clk);
    idle();
    for (int k = 0; k < 12; k++) begin
      wr_vld[k] = 1'b1;
      wr_idx[k] = k[0];
      wr_data[k*32 +: 32] = 32'hA000 + 32'(k);
    end
    @(negedge clk);
    idle();
    // R9: walk addresses on one port without a clock edge between reads.
    for (int k = 0; k < 12; k++) begin
      op_addr[4:0] = gaddr(k / 3, k % 3, k % 2);
      #1;
      chk($sformatf("R4 R9 write port %0d", k), op_data[31:0], 32'hA000 + 32'(k));
    end
    for (int s = 0; s < 4; s++) begin
      op_byp[1] = 1'b1;
      op_byp_slot[3:2] = 2'(s);
      #1;
      chk($sformatf("R6 back-to-back slot %0d", s), op_data[63:32], 32'hA000 + 32'(s * 3));
    end

    // R8: writes presented during reset are dropped.
    @(negedge clk);
    idle();
    rst = 1'b1;
    for (int k = 0; k < 12; k++) begin
      wr_vld[k] = 1'b1;
      wr_data[k*32 +: 32] = 32'hDEAD0000 + 32'(k);
    end
    @(negedge clk);
    idle();
    rst = 1'b0;
    model_reset();
    for (int p = 0; p < 8; p++) begin
      op_addr[p*5 +: 5] = gaddr(p / 2, 0, 0);
      op_byp[p] = p[0];
      op_byp_slot[p*2 +: 2] = 2'(p / 2);
    end
    #1;
    for (int p = 0; p < 8; p++) chk($sformatf("R8 after reset port %0d", p), op_data[p*32 +: 32], 32'h0);

    // Random traffic against the reference model (R1 R2 R3 R4 R5 R6).
    for (int cyc = 0; cyc < 400; cyc++) begin
      @(negedge clk);
      for (int k = 0; k < 12; k++) begin
        wr_vld[k] = 1'($urandom_range(0, 1));
        wr_idx[k] = 1'($urandom_range(0, 1));
        wr_data[k*32 +: 32] = $urandom;
      end
      for (int p = 0; p < 8; p++) begin
        op_addr[p*5 +: 5] = 5'($urandom_range(0, 31));
        op_byp[p] = ($urandom_range(0, 3) == 0);
        op_byp_slot[p*2 +: 2] = 2'($urandom_range(0, 3));
      end
      #1;
      for (int p = 0; p < 8; p++) begin
        logic [4:0]  a;
        logic [31:0] ed;
        logic        ee;
        a = op_addr[p*5 +: 5];
        if (op_byp[p]) begin
          ed = mfast[op_byp_slot[p*2 +: 2]]; ee = 1'b0;
        end else if (a[2:1] == 2'd3) begin
          ed = '0; ee = 1'b1;
        end else begin
          ed = mreg[int'(a[4:3]) * 3 + int'(a[2:1])][a[0]]; ee = 1'b0;
        end
        chk($sformatf("R1 random cyc %0d port %0d data", cyc, p), op_data[p*32 +: 32], ed);
        chk($sformatf("R5 random cyc %0d port %0d err", cyc, p), 32'(op_err[p]), 32'(ee));
      end
      model_commit();
    end

    @(negedge clk);
    idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule